// File: doc/BRIEF.md
# Page-Sized Virtually Indexed Data Cache with Physical Snoop Invalidation

This block is a direct-mapped, write-through data cache whose capacity is exactly one page of words. Because every index bit falls inside the untranslated page offset, the index taken from a virtual address equals the index taken from the matching physical address. The processor looks up the data, a validity bit and a virtual page tag with its virtual address. A second tag array holds the physical page number of each line. That array is written only when read data returns from memory, carrying its translated page number. It is read only to compare against write addresses seen on remote buses.

Four remote write sources feed the snoop side. Three are other processors and one is an I/O bus. Events that arrive in the same cycle enter a small queue in fixed source order, and one queued event is checked against the physical tags each cycle. A match clears that line's valid bit. Vector loads and stores never use cached data, and any line they hit is invalidated. All addresses are word addresses: the low `IDX_W` bits are the line index, and the bits above are the page number.

Top module: `vipt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` is 0 and `snp_ready` is 1, so the first load to any address misses.
- R2: A scalar load (`cpu_req`=1, `cpu_we`=0, `cpu_vec`=0) gives `rsp_valid`=1 in the next cycle. `rsp_hit` is 1 only when the indexed line is valid and its stored virtual page equals the address bits above the index. On a hit, `rsp_data` is the stored word.
- R3: A fill (`fill_valid`=1) writes the data word, the virtual page and the physical page `fill_ppn` into the line at `fill_vaddr`'s index and sets it valid, unless an invalidation at that index happens in the same cycle.
- R4: A scalar store updates the stored word only when the line hits (valid and virtual page equal). A store that misses changes nothing and allocates nothing. Stores give no response.
- R5: A vector load responds with `rsp_hit`=0. A vector load or store whose address would hit clears that line's valid bit. A vector store never changes stored data.
- R6: A queued snoop event with physical word address A clears the line at A's index when that line is valid and its physical page equals A's page bits. Otherwise the event has no effect.
- R7: Snoop events offered in the same cycle enter the queue in source order, with source 0 first. One event leaves the queue and is checked each cycle, oldest first. The check happens in the cycle after the event was accepted, at the earliest.
- R8: `snp_ready` is 1 exactly when the queue holds no more than `QDEPTH - NSRC` events. Events offered while `snp_ready` is 0 are dropped with no effect. The queue never exceeds `QDEPTH`.
- R9: An invalidation at the same index as a fill in the same cycle wins, and the line stays invalid. A checked snoop event whose page and index equal the fill's physical address also kills that fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access this cycle |
| cpu_we | input | 1 | Access is a store |
| cpu_vec | input | 1 | Access is a vector access (bypass) |
| cpu_vaddr | input | VA_W | Virtual word address |
| cpu_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load response valid (one cycle after the load) |
| rsp_hit | output | 1 | Load hit in the cache |
| rsp_data | output | DW | Cached word on a hit |
| fill_valid | input | 1 | Memory read data returns this cycle |
| fill_vaddr | input | VA_W | Virtual word address of the returning data |
| fill_ppn | input | PA_W-IDX_W | Translated physical page of the returning data |
| fill_data | input | DW | Returning data word |
| snp_valid | input | NSRC | Remote write seen, one bit per source |
| snp_addr | input | NSRC*PA_W | Physical word addresses, source s in bits [s*PA_W +: PA_W] |
| snp_ready | output | 1 | Snoop events are accepted this cycle |

## Verification
The hardest case to reach is a queued snoop event that gets checked in exactly the cycle a fill lands on the same index. The queue hides when an event is checked, so the bench first lets the queue drain to empty. It then offers one snoop and places the fill one cycle later, when that event is at the head. It also offers a snoop aimed at the page the fill itself carries, so that both kill paths are covered. Queue back-pressure is reached by offering four non-matching events per cycle for two cycles. A matching event is then offered while `snp_ready` is low, and a later load shows that the line survived.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

  localparam int unsigned DEF_VA_W   = 30;
  localparam int unsigned DEF_PA_W   = 30;
  localparam int unsigned DEF_IDX_W  = 6;
  localparam int unsigned DEF_DW     = 32;
  localparam int unsigned DEF_NSRC   = 4;
  localparam int unsigned DEF_QDEPTH = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_STORE,
    OP_VLOAD,
    OP_VSTORE
  } cpu_op_e;

  function automatic cpu_op_e decode_op(input logic req, input logic we, input logic vec);
    if (!req)     return OP_NONE;
    else if (vec) return we ? OP_VSTORE : OP_VLOAD;
    else          return we ? OP_STORE : OP_LOAD;
  endfunction

endpackage

// File: rtl/vipt_snoop_queue.sv
module vipt_snoop_queue #(
  parameter int unsigned W     = 30,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NSRC  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     push_vld,
  input  logic [NSRC*W-1:0]   push_data,
  output logic                room,
  output logic                head_vld,
  output logic [W-1:0]        head_data,
  output logic [CNT_W-1:0]    level
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned SEL_W = $clog2(NSRC + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] rank [NSRC];
  logic [SEL_W-1:0] n_push;

  function automatic logic has_room(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(DEPTH - NSRC);
  endfunction

  // Each valid source takes the next free slot in source order.
  always_comb begin
    n_push = '0;
    for (int s = 0; s < NSRC; s++) begin
      rank[s] = n_push;
      n_push  = n_push + SEL_W'(push_vld[s]);
    end
  end

  assign head_vld  = (count != '0);
  assign head_data = slots[rd_ptr];
  assign room      = has_room(count);
  assign level     = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(n_push);
      rd_ptr <= rd_ptr + PTR_W'(head_vld);
      count  <= count + CNT_W'(n_push) - CNT_W'(head_vld);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSRC; s++) begin
      if (push_vld[s]) slots[wr_ptr + PTR_W'(rank[s])] <= push_data[s*W +: W];
    end
  end

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned VPN_W = 24,
  parameter int unsigned PPN_W = 24,
  parameter int unsigned DW    = 32,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic              lk_valid,
  output logic [VPN_W-1:0]  lk_vpn,
  output logic [DW-1:0]     lk_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              sn_valid,
  output logic [PPN_W-1:0]  sn_ppn,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [DW-1:0]     fill_data,
  input  logic              snp_kill,
  input  logic              vec_kill,
  output logic [LINES-1:0]  valid_bits
);

  logic [DW-1:0]    data_q [LINES];
  logic [VPN_W-1:0] vtag_q [LINES];
  logic [PPN_W-1:0] ptag_q [LINES];
  logic [LINES-1:0] vld_q;

  assign lk_valid   = vld_q[cpu_idx];
  assign lk_vpn     = vtag_q[cpu_idx];
  assign lk_data    = data_q[cpu_idx];
  assign sn_valid   = vld_q[snp_idx];
  assign sn_ppn     = ptag_q[snp_idx];
  assign valid_bits = vld_q;

  // Later statements win: a kill at the fill index leaves the line invalid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (fill_en)  vld_q[fill_idx] <= 1'b1;
      if (snp_kill) vld_q[snp_idx]  <= 1'b0;
      if (vec_kill) vld_q[cpu_idx]  <= 1'b0;
    end
  end

  // Returning memory data overrides a same-cycle local store.
  always_ff @(posedge clk) begin
    if (wr_en) data_q[cpu_idx] <= wr_data;
    if (fill_en) begin
      data_q[fill_idx] <= fill_data;
      vtag_q[fill_idx] <= fill_vpn;
      ptag_q[fill_idx] <= fill_ppn;
    end
  end

endmodule

// File: rtl/vipt_snoop_cache.sv
module vipt_snoop_cache
  import vipt_cache_pkg::*;
#(
  parameter int unsigned VA_W   = DEF_VA_W,
  parameter int unsigned PA_W   = DEF_PA_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned NSRC   = DEF_NSRC,
  parameter int unsigned QDEPTH = DEF_QDEPTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic                   cpu_vec,
  input  logic [VA_W-1:0]        cpu_vaddr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [DW-1:0]          rsp_data,
  input  logic                   fill_valid,
  input  logic [VA_W-1:0]        fill_vaddr,
  input  logic [PA_W-IDX_W-1:0]  fill_ppn,
  input  logic [DW-1:0]          fill_data,
  input  logic [NSRC-1:0]        snp_valid,
  input  logic [NSRC*PA_W-1:0]   snp_addr,
  output logic                   snp_ready
);

  localparam int unsigned VPN_W = VA_W - IDX_W;
  localparam int unsigned PPN_W = PA_W - IDX_W;
  localparam int unsigned LINES = 1 << IDX_W;
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

  cpu_op_e op;
  logic    is_load, is_store, is_vec;

  logic [IDX_W-1:0] cpu_idx, fill_idx, sn_idx;
  logic [VPN_W-1:0] cpu_vpn, fill_vpn, lk_vpn;
  logic [PPN_W-1:0] sn_page, sn_ppn;
  logic             lk_valid, lk_hit, sn_valid;
  logic [DW-1:0]    lk_data;

  logic [NSRC-1:0]  q_push;
  logic             q_head_vld;
  logic [PA_W-1:0]  q_head;
  logic [CNT_W-1:0] q_level;

  // Named event wires, also watched by the checker.
  logic             loc_wr, vec_kill, snp_hit_old, snp_hit_fill, snp_kill, fill_lost;
  logic [LINES-1:0] valid_bits;

  assign op       = decode_op(cpu_req, cpu_we, cpu_vec);
  assign is_load  = (op == OP_LOAD);
  assign is_store = (op == OP_STORE);
  assign is_vec   = (op == OP_VLOAD) || (op == OP_VSTORE);

  assign cpu_idx  = cpu_vaddr[IDX_W-1:0];
  assign cpu_vpn  = cpu_vaddr[VA_W-1:IDX_W];
  assign fill_idx = fill_vaddr[IDX_W-1:0];
  assign fill_vpn = fill_vaddr[VA_W-1:IDX_W];
  assign sn_idx   = q_head[IDX_W-1:0];
  assign sn_page  = q_head[PA_W-1:IDX_W];

  assign q_push = snp_valid & {NSRC{snp_ready}};

  vipt_snoop_queue #(
    .W(PA_W), .DEPTH(QDEPTH), .NSRC(NSRC)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vld  (q_push),
    .push_data (snp_addr),
    .room      (snp_ready),
    .head_vld  (q_head_vld),
    .head_data (q_head),
    .level     (q_level)
  );

  assign lk_hit       = lk_valid && (lk_vpn == cpu_vpn);
  assign loc_wr       = is_store && lk_hit;
  assign vec_kill     = is_vec && lk_hit;
  assign snp_hit_old  = q_head_vld && sn_valid && (sn_ppn == sn_page);
  assign snp_hit_fill = q_head_vld && fill_valid && (fill_idx == sn_idx) && (fill_ppn == sn_page);
  assign snp_kill     = snp_hit_old || snp_hit_fill;
  assign fill_lost    = fill_valid && ((snp_kill && (sn_idx == fill_idx)) ||
                                       (vec_kill && (cpu_idx == fill_idx)));

  vipt_line_store #(
    .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .DW(DW)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_idx    (cpu_idx),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_data    (lk_data),
    .snp_idx    (sn_idx),
    .sn_valid   (sn_valid),
    .sn_ppn     (sn_ppn),
    .wr_en      (loc_wr),
    .wr_data    (cpu_wdata),
    .fill_en    (fill_valid),
    .fill_idx   (fill_idx),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_data  (fill_data),
    .snp_kill   (snp_kill),
    .vec_kill   (vec_kill),
    .valid_bits (valid_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= is_load || (op == OP_VLOAD);
      rsp_hit   <= is_load && lk_hit;
      rsp_data  <= lk_data;
    end
  end

endmodule

// File: rtl/vipt_snoop_cache_chk.sv
module vipt_snoop_cache_chk #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned NSRC   = 4,
  parameter int unsigned QDEPTH = 8,
  localparam int unsigned LINES = 1 << IDX_W,
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_vec,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fill_valid,
  input logic [IDX_W-1:0] fill_idx,
  input logic [IDX_W-1:0] cpu_idx,
  input logic [IDX_W-1:0] sn_idx,
  input logic             snp_kill,
  input logic             vec_kill,
  input logic             fill_lost,
  input logic [LINES-1:0] valid_bits,
  input logic [CNT_W-1:0] q_level,
  input logic             snp_ready
);

  p_load_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> rsp_valid);

  p_store_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we) |=> !rsp_valid);

  p_fill_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_lost) |=> valid_bits[$past(fill_idx)]);

  p_vec_never_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_vec) |=> !rsp_hit);

  p_vec_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_kill |=> !valid_bits[$past(cpu_idx)]);

  p_snoop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> !valid_bits[$past(sn_idx)]);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= CNT_W'(QDEPTH));

  p_full_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level > CNT_W'(QDEPTH - NSRC)) |-> !snp_ready);

  p_inval_beats_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lost |=> !valid_bits[$past(fill_idx)]);

endmodule

bind vipt_snoop_cache vipt_snoop_cache_chk #(
  .IDX_W(IDX_W), .NSRC(NSRC), .QDEPTH(QDEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_vec    (cpu_vec),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .fill_valid (fill_valid),
  .fill_idx   (fill_idx),
  .cpu_idx    (cpu_idx),
  .sn_idx     (sn_idx),
  .snp_kill   (snp_kill),
  .vec_kill   (vec_kill),
  .fill_lost  (fill_lost),
  .valid_bits (valid_bits),
  .q_level    (q_level),
  .snp_ready  (snp_ready)
);

// File: tb/vipt_snoop_cache_bench.sv
module vipt_snoop_cache_bench;

  localparam int VA_W  = 30;
  localparam int PA_W  = 30;
  localparam int IDX_W = 6;
  localparam int DW    = 32;
  localparam int NSRC  = 4;
  localparam int QD    = 8;
  localparam int LINES = 1 << IDX_W;
  localparam int VPN_W = VA_W - IDX_W;
  localparam int PPN_W = PA_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cpu_req = 0, cpu_we = 0, cpu_vec = 0;
  logic [VA_W-1:0]   cpu_vaddr = '0;
  logic [DW-1:0]     cpu_wdata = '0;
  logic              rsp_valid, rsp_hit;
  logic [DW-1:0]     rsp_data;
  logic              fill_valid = 0;
  logic [VA_W-1:0]   fill_vaddr = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic [DW-1:0]     fill_data = '0;
  logic [NSRC-1:0]   snp_valid = '0;
  logic [NSRC*PA_W-1:0] snp_addr = '0;
  logic              snp_ready;

  vipt_snoop_cache #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .DW(DW), .NSRC(NSRC), .QDEPTH(QD)
  ) u_vipt_snoop_cache (.*);

  // Staged stimulus for the next cycle.
  logic s_req, s_we, s_vec, s_fill;
  logic [VA_W-1:0]  s_va, s_fva;
  logic [DW-1:0]    s_wd, s_fd;
  logic [PPN_W-1:0] s_fppn;
  logic [NSRC-1:0]  s_snv;
  logic [PA_W-1:0]  s_sna [NSRC];

  // Behavioural reference model.
  logic             mv  [LINES];
  logic [DW-1:0]    md  [LINES];
  logic [VPN_W-1:0] mvt [LINES];
  logic [PPN_W-1:0] mpt [LINES];
  logic [PA_W-1:0]  mq  [$];
  logic             exp_rv, exp_hit;
  logic [DW-1:0]    exp_data;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", cur_req, what, act, expv);
    end
  endtask

  task automatic clear_stage();
    s_req = 0; s_we = 0; s_vec = 0; s_fill = 0; s_va = '0; s_fva = '0;
    s_wd = '0; s_fd = '0; s_fppn = '0; s_snv = '0;
    for (int s = 0; s < NSRC; s++) s_sna[s] = '0;
  endtask

  function automatic logic [VA_W-1:0] va(input int vpn, input int idx);
    return {VPN_W'(vpn), IDX_W'(idx)};
  endfunction

  function automatic logic [PA_W-1:0] pa(input int ppn, input int idx);
    return {PPN_W'(ppn), IDX_W'(idx)};
  endfunction

  task automatic model_cycle();
    int ci, si, fi;
    bit lh, rdy, have_h, skill, vkill, lwr;
    logic [PA_W-1:0] h;
    ci = int'(s_va[IDX_W-1:0]);
    fi = int'(s_fva[IDX_W-1:0]);
    lh = mv[ci] && (mvt[ci] == s_va[VA_W-1:IDX_W]);
    exp_rv   = s_req && !s_we;
    exp_hit  = exp_rv && !s_vec && lh;
    exp_data = md[ci];
    rdy    = (mq.size() <= QD - NSRC);
    have_h = (mq.size() > 0);
    h = '0;
    if (have_h) h = mq.pop_front();
    si = int'(h[IDX_W-1:0]);
    skill = have_h && ((mv[si] && mpt[si] == h[PA_W-1:IDX_W]) ||
                       (s_fill && fi == si && s_fppn == h[PA_W-1:IDX_W]));
    vkill = s_req && s_vec && lh;
    lwr   = s_req && s_we && !s_vec && lh;
    if (lwr) md[ci] = s_wd;
    if (s_fill) begin
      md[fi] = s_fd; mvt[fi] = s_fva[VA_W-1:IDX_W]; mpt[fi] = s_fppn; mv[fi] = 1'b1;
    end
    if (skill) mv[si] = 1'b0;
    if (vkill) mv[ci] = 1'b0;
    if (rdy) for (int s = 0; s < NSRC; s++) if (s_snv[s]) mq.push_back(s_sna[s]);
  endtask

  // One cycle: check last cycle's results, drive the staged stimulus, advance the model.
  task automatic step();
    @(negedge clk);
    chk(rsp_valid === exp_rv, "rsp_valid", rsp_valid, exp_rv);
    if (exp_rv) chk(rsp_hit === exp_hit, "rsp_hit", rsp_hit, exp_hit);
    if (exp_rv && exp_hit) chk(rsp_data === exp_data, "rsp_data", rsp_data, exp_data);
    chk(snp_ready === (mq.size() <= QD - NSRC), "snp_ready", snp_ready, mq.size() <= QD - NSRC);
    cpu_req = s_req; cpu_we = s_we; cpu_vec = s_vec; cpu_vaddr = s_va; cpu_wdata = s_wd;
    fill_valid = s_fill; fill_vaddr = s_fva; fill_ppn = s_fppn; fill_data = s_fd;
    snp_valid = s_snv;
    for (int s = 0; s < NSRC; s++) snp_addr[s*PA_W +: PA_W] = s_sna[s];
    model_cycle();
    clear_stage();
  endtask

  task automatic do_load(input int vpn, input int idx);
    s_req = 1; s_va = va(vpn, idx); step();
  endtask
  task automatic do_fill(input int vpn, input int idx, input int ppn, input int d);
    s_fill = 1; s_fva = va(vpn, idx); s_fppn = PPN_W'(ppn); s_fd = DW'(d); step();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    clear_stage();
    for (int i = 0; i < LINES; i++) mv[i] = 1'b0;
    exp_rv = 0; exp_hit = 0; exp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, loads miss everywhere
    cur_req = "R1";
    idle(2);
    for (int i = 0; i < 8; i++) do_load(i, i * 7);
    step();

    // R3: fill then hit
    cur_req = "R3";
    do_fill(3, 5, 'h41, 'h1234_5678);
    do_load(3, 5);
    step();

    // R2: other virtual page at same index misses, hit returns data
    cur_req = "R2";
    do_load(4, 5);
    do_load(3, 5);
    step();

    // R4: store hit updates, store miss does not allocate
    cur_req = "R4";
    s_req = 1; s_we = 1; s_va = va(3, 5); s_wd = 'hCAFE_0001; step();
    do_load(3, 5);
    s_req = 1; s_we = 1; s_va = va(9, 6); s_wd = 'hDEAD_0002; step();
    do_load(9, 6);
    step();

    // R5: vector load never hits and clears the line; vector store too
    cur_req = "R5";
    s_req = 1; s_vec = 1; s_va = va(3, 5); step();
    do_load(3, 5);
    do_fill(2, 7, 'h50, 'h77);
    s_req = 1; s_vec = 1; s_we = 1; s_va = va(2, 7); s_wd = 'h99; step();
    do_load(2, 7);
    step();

    // R6: matching snoop clears, mismatching page leaves line
    cur_req = "R6";
    do_fill(1, 10, 'h61, 'hA);
    do_fill(1, 11, 'h62, 'hB);
    s_snv[0] = 1; s_sna[0] = pa('h61, 10); s_snv[1] = 1; s_sna[1] = pa('h99, 11); step();
    idle(3);
    do_load(1, 10);
    do_load(1, 11);
    step();

    // R7: four simultaneous snoops drain one per cycle in source order
    cur_req = "R7";
    for (int i = 0; i < 4; i++) do_fill(1, 20 + i, 'h70 + i, i);
    for (int s = 0; s < NSRC; s++) begin s_snv[s] = 1; s_sna[s] = pa('h70 + s, 20 + s); end
    step();
    for (int i = 0; i < 4; i++) do_load(1, 20 + (3 - i));
    do_load(1, 20);
    step();

    // R8: flood the queue, offer a matching snoop while not ready
    cur_req = "R8";
    do_fill(1, 30, 'h80, 'h55);
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < NSRC; s++) begin s_snv[s] = 1; s_sna[s] = pa('h3FF, s); end
      step();
    end
    s_snv[2] = 1; s_sna[2] = pa('h80, 30); step();
    idle(10);
    do_load(1, 30);
    step();

    // R9: snoop checked in the same cycle as a fill to its index
    cur_req = "R9";
    do_fill(1, 40, 'h90, 'h1);
    idle(2);
    s_snv[0] = 1; s_sna[0] = pa('h90, 40); step();
    do_fill(5, 40, 'h91, 'h2);
    do_load(5, 40);
    s_snv[3] = 1; s_sna[3] = pa('h92, 41); step();
    do_fill(5, 41, 'h92, 'h3);
    do_load(5, 41);
    do_fill(6, 42, 'h93, 'h4);
    s_req = 1; s_vec = 1; s_va = va(6, 42); s_fill = 1; s_fva = va(6, 42); s_fppn = 'h94; s_fd = 'h5; step();
    do_load(6, 42);
    step();

    // Mixed traffic covering R2 R3 R4 R5 R6 R7 R8 R9 together
    cur_req = "R2-mix";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 55) begin
        s_req = 1; s_va = va(int'($urandom_range(1, 2)), int'($urandom_range(0, 7)));
        if (r >= 30 && r < 45) begin s_we = 1; s_wd = $urandom; end
        else if (r >= 45) begin s_vec = 1; s_we = $urandom_range(0, 1); end
      end
      if ($urandom_range(0, 3) == 0) begin
        s_fill = 1; s_fva = va(int'($urandom_range(1, 2)), int'($urandom_range(0, 7)));
        s_fppn = PPN_W'('h40 + $urandom_range(1, 2)); s_fd = $urandom;
      end
      for (int s = 0; s < NSRC; s++) begin
        if ($urandom_range(0, 4) == 0) begin
          s_snv[s] = 1; s_sna[s] = pa(int'('h40 + $urandom_range(1, 2)), int'($urandom_range(0, 7)));
        end
      end
      step();
    end
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule